// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of an integer-N frequency synthesizer. It runs entirely on the fast oscillator clock and emits a single-cycle pulse once every N input cycles. That pulse is the divided signal handed to a phase comparator. The ratio is N = 64·B + A.

Internally a dual-modulus prescaler divides by 65 or by 64. The prescaler is a synchronous divide-by-4/5 core followed by a divide-by-16 stage. Two down-counters steer it. The swallow counter (A, 6 bits) keeps the prescaler at 65 for the opening A prescaler cycles of each output period. The main counter (B, 9 bits) ends the period after B prescaler cycles.

Software-side logic writes A and B through a parallel load port with a strobe. Written values wait in a pending stage and are only adopted at a period boundary. A setting that cannot be divided (B of zero, or B below A) stops the divider and raises a flag.

Top module: `psw_feedback_divider`

## Requirements
- R1: A synchronous active-low reset clears every counter and both configuration stages. While reset is applied and afterwards, `div_pulse` and `mod_sel` are 0 and `cfg_invalid` is 1, because an all-zero configuration is unusable.
- R2: With a usable active configuration, `div_pulse` is high for exactly one cycle every N = 64·B + A input cycles. This holds from the smallest ratio (A=0, B=1, N=64) to the largest (A=63, B=511, N=32767).
- R3: `mod_sel` is 1 during the first 65·A input cycles of each output period and 0 for the rest. The cycle in which `div_pulse` is high counts as the first cycle of the new period. With A equal to B the whole period runs at 65.
- R4: A strobe on `ld_stb` captures `ld_swallow` and `ld_main` into a pending stage. The period in progress completes with its old ratio, and the new ratio applies from the period that starts with the next pulse.
- R5: When the active setting has B equal to 0, or B smaller than A, `cfg_invalid` is 1, the counters are held, and `div_pulse` and `mod_sel` stay 0. This continues until a usable value is loaded.
- R6: While the divider is halted, a usable value is taken up without waiting for a boundary. Counting the rising edge that captures the strobe as edge 1, the first pulse follows edge N+2.
- R7: A reset applied in the middle of a period stops output at once. After release the divider stays halted and silent until a new load.
- R8: Changes on `ld_swallow` and `ld_main` while `ld_stb` is low have no effect on the ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_stb | input | 1 | Load strobe for the pending ratio values |
| ld_swallow | input | 6 | Swallow count A to load |
| ld_main | input | 9 | Main count B to load |
| div_pulse | output | 1 | One-cycle divided output pulse |
| mod_sel | output | 1 | Prescaler modulus in use (1 = divide by 65) |
| cfg_invalid | output | 1 | Active ratio setting is unusable; divider halted |

## Verification
The bench builds the block at its default widths: a 6-bit swallow count, a 9-bit main count and a 16-step stage after the 4/5 core. This gives a 64/65 prescaler, so the bench can reach both the shortest period of 64 cycles and the longest of 32767 cycles. At these widths the prescaler's prescribed 65-cycle stretch and the A=B case, where every prescaler cycle is stretched, can be checked directly against the modulus count of a whole period. The bench also covers loads in mid-period, halting settings, the restart from halt, and a reset in mid-period.

// File: rtl/psw_div_pkg.sv
package psw_div_pkg;

  // Cycles of the core in its short mode.
  localparam int unsigned CORE_SHORT = 4;

  // A setting is usable when the main count is nonzero and not below the swallow count.
  function automatic logic cfg_usable(input int unsigned swallow, input int unsigned main_cnt);
    return (main_cnt != 0) && (main_cnt >= swallow);
  endfunction

  // Last state of the 4/5 core: it stretches only in the final core cycle of a stretched prescaler cycle.
  function automatic logic [2:0] core_last(input logic final_step, input logic stretch);
    return (final_step && stretch) ? 3'd4 : 3'd3;
  endfunction

endpackage

// File: rtl/psw_cfg_regs.sv
module psw_cfg_regs #(
  parameter int unsigned A_W = 6,
  parameter int unsigned B_W = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_stb,
  input  logic [A_W-1:0] ld_swallow,
  input  logic [B_W-1:0] ld_main,
  input  logic           take,
  output logic [A_W-1:0] pend_a,
  output logic [B_W-1:0] pend_b,
  output logic [A_W-1:0] act_a,
  output logic [B_W-1:0] act_b
);

  // Pending stage: written by the strobe.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_a <= '0;
      pend_b <= '0;
    end else if (ld_stb) begin
      pend_a <= ld_swallow;
      pend_b <= ld_main;
    end
  end

  // Active stage: adopts the pending values at a boundary or while halted.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_a <= '0;
      act_b <= '0;
    end else if (take) begin
      act_a <= pend_a;
      act_b <= pend_b;
    end
  end

endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler
  import psw_div_pkg::*;
#(
  parameter int unsigned STG_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic modulus,
  output logic pre_tc,
  output logic core_fifth
);

  localparam logic [STG_W-1:0] STG_LAST = {STG_W{1'b1}};

  logic [2:0]       core_q;
  logic [STG_W-1:0] stg_q;
  logic             final_step;
  logic             core_end;

  assign final_step = (stg_q == STG_LAST);
  assign core_end   = (core_q == core_last(final_step, modulus));
  assign pre_tc     = core_end && final_step;
  assign core_fifth = (core_q == 3'(CORE_SHORT));

  // 4/5 core followed by the divide-by-2^STG_W stage.
  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      core_q <= '0;
      stg_q  <= '0;
    end else begin
      core_q <= core_end ? 3'd0 : core_q + 3'd1;
      if (core_end) begin
        stg_q <= stg_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/psw_swallow_ctl.sv
module psw_swallow_ctl #(
  parameter int unsigned A_W = 6,
  parameter int unsigned B_W = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           pre_tc,
  input  logic [A_W-1:0] nxt_a,
  input  logic [B_W-1:0] nxt_b,
  output logic           modulus,
  output logic           period_end,
  output logic [A_W-1:0] a_cnt,
  output logic [B_W-1:0] b_cnt
);

  localparam logic [B_W-1:0] B_ONE = B_W'(1);

  assign modulus    = run && (a_cnt != '0);
  assign period_end = run && pre_tc && (b_cnt == B_ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_cnt <= '0;
      b_cnt <= '0;
    end else if (!run || period_end) begin
      a_cnt <= nxt_a;
      b_cnt <= nxt_b;
    end else if (pre_tc) begin
      b_cnt <= b_cnt - 1'b1;
      if (a_cnt != '0) begin
        a_cnt <= a_cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/psw_feedback_divider.sv
module psw_feedback_divider
  import psw_div_pkg::*;
#(
  parameter int unsigned A_W   = 6,
  parameter int unsigned B_W   = 9,
  parameter int unsigned STG_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_stb,
  input  logic [A_W-1:0] ld_swallow,
  input  logic [B_W-1:0] ld_main,
  output logic           div_pulse,
  output logic           mod_sel,
  output logic           cfg_invalid
);

  logic [A_W-1:0] pend_a, act_a, a_cnt;
  logic [B_W-1:0] pend_b, act_b, b_cnt;
  logic           run;
  logic           take_cfg;
  logic           pre_tc;
  logic           core_fifth;
  logic           period_end;
  logic           pulse_q;

  assign run         = cfg_usable(32'(act_a), 32'(act_b));
  assign take_cfg    = !run || period_end;
  assign cfg_invalid = !run;

  psw_cfg_regs #(.A_W(A_W), .B_W(B_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_stb     (ld_stb),
    .ld_swallow (ld_swallow),
    .ld_main    (ld_main),
    .take       (take_cfg),
    .pend_a     (pend_a),
    .pend_b     (pend_b),
    .act_a      (act_a),
    .act_b      (act_b)
  );

  psw_prescaler #(.STG_W(STG_W)) u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .modulus    (mod_sel),
    .pre_tc     (pre_tc),
    .core_fifth (core_fifth)
  );

  psw_swallow_ctl #(.A_W(A_W), .B_W(B_W)) u_sw (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .pre_tc     (pre_tc),
    .nxt_a      (pend_a),
    .nxt_b      (pend_b),
    .modulus    (mod_sel),
    .period_end (period_end),
    .a_cnt      (a_cnt),
    .b_cnt      (b_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= period_end;
    end
  end

  assign div_pulse = pulse_q;

endmodule

// File: rtl/psw_feedback_divider_chk.sv
module psw_feedback_divider_chk #(
  parameter int unsigned A_W = 6,
  parameter int unsigned B_W = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           div_pulse,
  input logic           mod_sel,
  input logic           cfg_invalid,
  input logic           pre_tc,
  input logic           core_fifth,
  input logic           period_end,
  input logic [A_W-1:0] act_a,
  input logic [B_W-1:0] act_b,
  input logic [A_W-1:0] a_cnt,
  input logic [B_W-1:0] b_cnt
);

  AST_PULSE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse); // R2

  AST_PULSE_ON_PRESCALER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> $past(pre_tc)); // R2

  AST_STRETCH_NEEDS_MODULUS: assert property (@(posedge clk) disable iff (!rst_n)
    core_fifth |-> mod_sel); // R3

  AST_MODULUS_DROPS_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_sel) |-> $past(pre_tc)); // R3

  AST_ACTIVE_FROZEN_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cfg_invalid) && !$past(period_end)) |-> ($stable(act_a) && $stable(act_b))); // R4

  AST_COUNTS_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_invalid |-> ((b_cnt != '0) && (32'(b_cnt) >= 32'(a_cnt)))); // R5

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_invalid && $past(cfg_invalid)) |-> !div_pulse); // R5

endmodule

bind psw_feedback_divider psw_feedback_divider_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .div_pulse   (div_pulse),
  .mod_sel     (mod_sel),
  .cfg_invalid (cfg_invalid),
  .pre_tc      (pre_tc),
  .core_fifth  (core_fifth),
  .period_end  (period_end),
  .act_a       (act_a),
  .act_b       (act_b),
  .a_cnt       (a_cnt),
  .b_cnt       (b_cnt)
);

// File: tb/tb_psw_feedback_divider.sv
`timescale 1ns/1ps
module tb_psw_feedback_divider;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_stb = 1'b0;
  logic [5:0] ld_swallow = '0;
  logic [8:0] ld_main = '0;
  logic       div_pulse, mod_sel, cfg_invalid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;

  always #2.5 clk = ~clk;

  psw_feedback_divider dut (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_swallow(ld_swallow),
    .ld_main(ld_main), .div_pulse(div_pulse), .mod_sel(mod_sel), .cfg_invalid(cfg_invalid)
  );

  function automatic bit usable(int a, int b);
    return (b > 0) && !(a > b);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Behavioural reference: pending/active pair and an elapsed-cycle count.
  int  m_pa = 0, m_pb = 0, m_aa = 0, m_ab = 0, m_e = 0;
  bit  m_pulse = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_pa = 0; m_pb = 0; m_aa = 0; m_ab = 0; m_e = 0; m_pulse = 1'b0;
    end else begin
      if (usable(m_aa, m_ab)) begin
        if (m_e == 64 * m_ab + m_aa - 1) begin
          m_pulse = 1'b1; m_e = 0; m_aa = m_pa; m_ab = m_pb;
        end else begin
          m_pulse = 1'b0; m_e++;
        end
      end else begin
        m_pulse = 1'b0; m_e = 0; m_aa = m_pa; m_ab = m_pb;
      end
      if (ld_stb) begin
        m_pa = int'(ld_swallow); m_pb = int'(ld_main);
      end
    end
    if (cyc == 2) cmp_en = 1'b1;
    if (cyc >= 199000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  // Per-cycle comparison against the reference.
  always @(negedge clk) begin
    if (cmp_en) begin
      check(div_pulse === m_pulse, "R2 pulse timing", int'(div_pulse), int'(m_pulse));
      check(mod_sel === (usable(m_aa, m_ab) && (m_e < 65 * m_aa)), "R3 modulus",
            int'(mod_sel), int'(usable(m_aa, m_ab) && (m_e < 65 * m_aa)));
      check(cfg_invalid === !usable(m_aa, m_ab), "R5 invalid flag",
            int'(cfg_invalid), int'(!usable(m_aa, m_ab)));
    end
  end

  task automatic load(int a, int b);
    @(negedge clk);
    ld_stb = 1'b1; ld_swallow = 6'(a); ld_main = 9'(b);
    @(negedge clk);
    ld_stb = 1'b0;
  endtask

  task automatic wait_pulse();
    @(negedge clk);
    while (div_pulse !== 1'b1) @(negedge clk);
  endtask

  // Starts on a pulse cycle; measures the gap and the modulus-high cycles to the next pulse.
  task automatic gap(int exp_n, int exp_m, string req);
    int n = 0;
    int m = 0;
    do begin
      if (mod_sel) m++;
      @(negedge clk);
      n++;
    end while (div_pulse !== 1'b1 && n < 40000);
    check(n == exp_n, req, n, exp_n);
    check(m == exp_m, "R3 modulus cycles per period", m, exp_m);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(div_pulse === 1'b0, "R1 pulse low in reset", int'(div_pulse), 0);
    check(mod_sel === 1'b0, "R1 modulus low in reset", int'(mod_sel), 0);
    check(cfg_invalid === 1'b1, "R1 invalid after reset", int'(cfg_invalid), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(div_pulse === 1'b0, "R1 quiet after release", int'(div_pulse), 0);

    // Smallest ratio.
    load(0, 1);
    wait_pulse();
    gap(64, 0, "R2 N=64");
    gap(64, 0, "R2 N=64 repeat");

    // R4: load in mid-period; old period must finish unchanged.
    ld_stb = 1'b1; ld_swallow = 6'd3; ld_main = 9'd5;
    @(negedge clk);
    ld_stb = 1'b0;
    begin
      int n = 1;
      while (div_pulse !== 1'b1 && n < 40000) begin @(negedge clk); n++; end
      check(n == 64, "R4 old ratio completes", n, 64);
    end
    gap(323, 195, "R4 new ratio N=323");

    // R8: data moves without strobe.
    ld_swallow = 6'd9; ld_main = 9'd20;
    gap(323, 195, "R8 no strobe no change");
    gap(323, 195, "R8 no strobe no change again");

    // A equal to B: every prescaler cycle stretched.
    load(5, 5);
    wait_pulse();
    gap(325, 325, "R3 A=B N=325");
    load(63, 63);
    wait_pulse();
    gap(4095, 4095, "R2 N=4095");

    // Largest ratio.
    load(63, 511);
    wait_pulse();
    gap(32767, 4095, "R2 N=32767");

    // R5: B below A halts at the next boundary.
    load(4, 2);
    while (cfg_invalid !== 1'b1) @(negedge clk);
    begin
      int seen = 0;
      for (int i = 0; i < 500; i++) begin
        @(negedge clk);
        if (div_pulse || mod_sel || !cfg_invalid) seen++;
      end
      check(seen == 0, "R5 halted with B<A", seen, 0);
    end
    load(0, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (div_pulse || mod_sel || !cfg_invalid) seen++;
      end
      check(seen == 0, "R5 halted with B=0", seen, 0);
    end

    // R6: restart from halt, first pulse after edge N+2.
    @(negedge clk);
    ld_stb = 1'b1; ld_swallow = 6'd1; ld_main = 9'd2;
    begin
      int c = 0;
      do begin
        @(negedge clk);
        ld_stb = 1'b0;
        c++;
      end while (div_pulse !== 1'b1 && c < 40000);
      check(c == 131, "R6 restart latency", c, 131);
    end
    gap(129, 65, "R6 N=129 after restart");

    // R7: reset in mid-period.
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(div_pulse === 1'b0, "R7 pulse low in reset", int'(div_pulse), 0);
    check(mod_sel === 1'b0, "R7 modulus low in reset", int'(mod_sel), 0);
    check(cfg_invalid === 1'b1, "R7 halted in reset", int'(cfg_invalid), 1);
    rst_n = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (div_pulse) seen++;
      end
      check(seen == 0, "R7 silent after reset", seen, 0);
    end
    finish_run();
  end

endmodule